// File: doc/BRIEF.md
# Microstep Electrical Angle Sequencer

This block turns a slow motor step strobe into per-coil current targets for a two-phase bipolar stepping motor. It holds a 7-bit electrical angle index covering one electrical revolution in 128 positions, where one position equals 2.8125 degrees. Each rising edge of the step strobe, once brought into the system clock domain, moves the index forward or backward by a stride that depends on the selected resolution. Each coil gets an 8-bit magnitude and a sign bit that are derived from the index through a quarter-wave sine table and scaled by a torque setting. The current regulation loop that follows this block uses those targets.

A four-state machine sets what the sequencer does on each system clock. The inputs are decoded in priority order. A resolution code of 000 selects STANDBY, a high home input selects HOME, a low enable selects OFF, and otherwise the machine is in RUN. Any state can move to any other state on the next clock as soon as these inputs change. In HOME the index is forced to the 45-degree position. In RUN a detected step edge moves the index. In OFF and STANDBY the index is frozen. Only RUN, and HOME while enabled, drive the output stage.

Top module: `stepseq_top`

## Requirements
- R1: The asynchronous reset (rst_n low) puts the index at 16, the 45-degree home position. Once reset is released, with enable high and a non-zero resolution code, the outputs show the home targets, home_n is low, and out_en and chop_run are high.
- R2: Only a rising edge of step_in moves the index. The edge passes through a two-flop synchronizer, and the outputs reflect it within six system clocks. A falling edge of step_in changes nothing.
- R3: The stride per step is set by res_code: 001 gives 32, 010 gives 16, 011 gives 8, 100 gives 16, 101 gives 4, 110 gives 2 and 111 gives 1. The index adds the stride when dir_cw is 1 and subtracts it when dir_cw is 0, wrapping modulo 128.
- R4: Let S(k) = round(255*sin(k*pi/64)) for k = 0..32. Let p be an index, with quadrant q = p[6:5] and offset o = p[4:0]. The raw sine of p is S(o) when q is even and S(32-o) when q is odd, and it is negative when p[6] is 1 and the raw value is non-zero. Channel B uses p equal to the index. Channel A uses p equal to the index plus 32, which gives a cosine.
- R5: For res_code 001 (full step) and 010 (square half step), every non-zero raw magnitude is replaced by 255. For all other codes, including 100 (sine half step), the sine value is used as it is, so the home position gives 180, about 71%.
- R6: The driven magnitude is floor(raw*(2+torque)/5), so torque codes 00, 01, 10 and 11 give 40%, 60%, 80% and 100%.
- R7: While home_i is high, the index is forced to 16 and step edges are ignored.
- R8: home_n is low exactly when the index is 16, and high otherwise.
- R9: While enable_i is low (and res_code is non-zero), out_en is 0, both magnitudes and both sign bits are 0, and steps are ignored. When enable returns, the index is the same as before.
- R10: Resolution code 000 is standby. In standby, out_en and chop_run are 0, the magnitudes are 0, steps are ignored, and the index is kept for the next non-zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Asynchronous step strobe; rising edge advances |
| dir_cw | input | 1 | Direction, 1 increments the index |
| res_code | input | 3 | Step resolution, 000 is standby |
| torque | input | 2 | Amplitude scale, 40/60/80/100% |
| enable_i | input | 1 | Output stage enable |
| home_i | input | 1 | Force index to home position |
| a_mag | output | 8 | Channel A target magnitude |
| a_neg | output | 1 | Channel A target negative |
| b_mag | output | 8 | Channel B target magnitude |
| b_neg | output | 1 | Channel B target negative |
| out_en | output | 1 | Output stage on |
| chop_run | output | 1 | Chopping clock may run (not standby) |
| home_n | output | 1 | Low while at the home index |

## Verification
The bench makes runs of 1/32 clockwise steps that cross every quadrant boundary, which shows whether the sine folding and the sign selection are correct. It makes 1/16 counter-clockwise steps through the wrap at index 0, which checks the modulo arithmetic. Full, square-half, sine-half and quarter steps taken from home show whether the saturated magnitude is applied to the right codes. Each torque code is applied at a fixed angle to check the scale factor alone. Step edges sent while disabled, in standby and during home, followed by a return to RUN, show that these states preserve the index rather than clear it.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    localparam int IDX_W   = 7;
    localparam int MAG_W   = 8;
    localparam int QTR     = 1 << (IDX_W - 2);
    localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(QTR / 2);

    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_HOME,
        ST_OFF,
        ST_RUN
    } seq_state_e;

    localparam logic [2:0] RES_STBY     = 3'd0;
    localparam logic [2:0] RES_FULL     = 3'd1;
    localparam logic [2:0] RES_HALF_SQ  = 3'd2;
    localparam logic [2:0] RES_QUARTER  = 3'd3;
    localparam logic [2:0] RES_HALF_SIN = 3'd4;
    localparam logic [2:0] RES_EIGHTH   = 3'd5;
    localparam logic [2:0] RES_SIXTEEN  = 3'd6;
    localparam logic [2:0] RES_THIRTY2  = 3'd7;

    function automatic logic [IDX_W-1:0] stride_of(input logic [2:0] r);
        case (r)
            RES_FULL:     return IDX_W'(32);
            RES_HALF_SQ:  return IDX_W'(16);
            RES_QUARTER:  return IDX_W'(8);
            RES_HALF_SIN: return IDX_W'(16);
            RES_EIGHTH:   return IDX_W'(4);
            RES_SIXTEEN:  return IDX_W'(2);
            RES_THIRTY2:  return IDX_W'(1);
            default:      return IDX_W'(0);
        endcase
    endfunction

    // Quarter-wave sine, 255 full scale, 33 points from 0 to 90 degrees.
    function automatic logic [MAG_W-1:0] quarter_sine(input logic [5:0] k);
        case (k)
            6'd0:  return 8'd0;    6'd1:  return 8'd13;
            6'd2:  return 8'd25;   6'd3:  return 8'd37;
            6'd4:  return 8'd50;   6'd5:  return 8'd62;
            6'd6:  return 8'd74;   6'd7:  return 8'd86;
            6'd8:  return 8'd98;   6'd9:  return 8'd109;
            6'd10: return 8'd120;  6'd11: return 8'd131;
            6'd12: return 8'd142;  6'd13: return 8'd152;
            6'd14: return 8'd162;  6'd15: return 8'd171;
            6'd16: return 8'd180;  6'd17: return 8'd189;
            6'd18: return 8'd197;  6'd19: return 8'd205;
            6'd20: return 8'd212;  6'd21: return 8'd219;
            6'd22: return 8'd225;  6'd23: return 8'd231;
            6'd24: return 8'd236;  6'd25: return 8'd240;
            6'd26: return 8'd244;  6'd27: return 8'd247;
            6'd28: return 8'd250;  6'd29: return 8'd252;
            6'd30: return 8'd254;  6'd31: return 8'd255;
            default: return 8'd255;
        endcase
    endfunction

endpackage

// File: rtl/stepseq_edge_sync.sv
module stepseq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];

    // R2: one strobe edge yields a single-cycle pulse
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/stepseq_angle_fsm.sv
module stepseq_angle_fsm
    import stepseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_rise,
    input  logic             dir_cw,
    input  logic [2:0]       res_code,
    input  logic             enable_i,
    input  logic             home_i,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] idx_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        if (res_code == RES_STBY) state_d = ST_STANDBY;
        else if (home_i)          state_d = ST_HOME;
        else if (!enable_i)       state_d = ST_OFF;
        else                      state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOME;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= HOME_IDX;
        end else begin
            unique case (state_q)
                ST_HOME:    idx_o <= HOME_IDX;
                ST_RUN: begin
                    if (step_rise) begin
                        if (dir_cw) idx_o <= idx_o + stride_of(res_code);
                        else        idx_o <= idx_o - stride_of(res_code);
                    end
                end
                ST_OFF:     idx_o <= idx_o;
                ST_STANDBY: idx_o <= idx_o;
            endcase
        end
    end

    assign state_o = state_q;

    assert_home_angle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOME) |=> (idx_o == HOME_IDX));
    assert_standby_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY) |=> $stable(idx_o));
    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> $stable(idx_o));
    assert_run_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step_rise && res_code != RES_STBY) |=> (idx_o != $past(idx_o)));
endmodule

// File: rtl/stepseq_phase.sv
module stepseq_phase
    import stepseq_pkg::*;
#(
    parameter int PHASE_OFS = 0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       res_code,
    input  logic [1:0]       torque,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o
);
    localparam int PROD_W = MAG_W + 3;

    logic [IDX_W-1:0]  pos;
    logic [5:0]        k;
    logic [MAG_W-1:0]  raw, shaped;
    logic [PROD_W-1:0] prod;
    logic [2:0]        weight;

    always_comb begin
        pos = idx + IDX_W'(PHASE_OFS);
        if (pos[IDX_W-2]) k = 6'(QTR) - {1'b0, pos[IDX_W-3:0]};
        else              k = {1'b0, pos[IDX_W-3:0]};
        raw = quarter_sine(k);
        if ((res_code == RES_FULL || res_code == RES_HALF_SQ) && raw != '0)
            shaped = '1;
        else
            shaped = raw;
        weight = 3'd2 + {1'b0, torque};
        prod   = PROD_W'(shaped) * PROD_W'(weight);
        mag_o  = MAG_W'(prod / PROD_W'(5));
        neg_o  = pos[IDX_W-1] & (shaped != '0);
    end

    // R6: scaling never increases the magnitude
    always_comb begin
        assert_scale_bound_R6: assert (mag_o <= shaped);
    end
endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
    import stepseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_in,
    input  logic       dir_cw,
    input  logic [2:0] res_code,
    input  logic [1:0] torque,
    input  logic       enable_i,
    input  logic       home_i,
    output logic [7:0] a_mag,
    output logic       a_neg,
    output logic [7:0] b_mag,
    output logic       b_neg,
    output logic       out_en,
    output logic       chop_run,
    output logic       home_n
);
    logic             step_rise;
    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [MAG_W-1:0] ch_mag [2];
    logic             ch_neg [2];
    logic             drive;

    stepseq_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(step_in), .rise_o(step_rise)
    );

    stepseq_angle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .step_rise(step_rise), .dir_cw(dir_cw),
        .res_code(res_code), .enable_i(enable_i), .home_i(home_i),
        .state_o(state), .idx_o(idx)
    );

    // Channel 0 is A (cosine, +90 degrees), channel 1 is B (sine).
    for (genvar c = 0; c < 2; c++) begin : g_ch
        stepseq_phase #(.PHASE_OFS(c == 0 ? QTR : 0)) u_phase (
            .idx(idx), .res_code(res_code), .torque(torque),
            .mag_o(ch_mag[c]), .neg_o(ch_neg[c])
        );
    end

    assign drive = (state == ST_RUN) || (state == ST_HOME && enable_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            chop_run <= 1'b0;
            home_n   <= 1'b0;
            a_mag    <= '0;
            a_neg    <= 1'b0;
            b_mag    <= '0;
            b_neg    <= 1'b0;
        end else begin
            out_en   <= drive;
            chop_run <= (state != ST_STANDBY);
            home_n   <= (idx != HOME_IDX);
            a_mag    <= drive ? ch_mag[0] : '0;
            a_neg    <= drive & ch_neg[0];
            b_mag    <= drive ? ch_mag[1] : '0;
            b_neg    <= drive & ch_neg[1];
        end
    end

    assert_home_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == HOME_IDX) |=> !home_n);
    assert_standby_chop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY) |=> (!chop_run && !out_en));
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (a_mag == '0 && b_mag == '0 && !out_en));
endmodule

// File: tb/sim_stepseq_top.sv
module sim_stepseq_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 1'b0, dir_cw = 1'b1, enable_i = 1'b1, home_i = 1'b0;
    logic [2:0] res_code = 3'd7;
    logic [1:0] torque = 2'd3;
    logic [7:0] a_mag, b_mag;
    logic a_neg, b_neg, out_en, chop_run, home_n;

    int n_chk = 0, n_bad = 0;
    int m_idx = 16;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepseq_top u0 (.*);

    function automatic int sine_pt(int k);
        real pi = 3.14159265358979;
        return $rtoi(255.0 * $sin(k * pi / 64.0) + 0.5);
    endfunction

    function automatic int raw_of(int p);
        int q = (p / 32) % 4;
        int o = p % 32;
        int r = (q % 2 == 1) ? sine_pt(32 - o) : sine_pt(o);
        if ((res_code == 3'd1 || res_code == 3'd2) && r != 0) r = 255;
        return r;
    endfunction

    function automatic int stride(logic [2:0] r);
        case (r)
            3'd1: return 32; 3'd2: return 16; 3'd3: return 8; 3'd4: return 16;
            3'd5: return 4;  3'd6: return 2;  3'd7: return 1; default: return 0;
        endcase
    endfunction

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, bit drv);
        int pb = m_idx % 128;
        int pa = (m_idx + 32) % 128;
        int ra = raw_of(pa), rb = raw_of(pb);
        int ea = drv ? (ra * (2 + torque)) / 5 : 0;
        int eb = drv ? (rb * (2 + torque)) / 5 : 0;
        bit ean = drv && pa >= 64 && ra != 0;
        bit ebn = drv && pb >= 64 && rb != 0;
        bit eh = (pb != 16);
        n_chk++;
        if (a_mag != ea || b_mag != eb || a_neg != ean || b_neg != ebn ||
            out_en != drv || home_n != eh) begin
            n_bad++;
            $display("FAIL %s idx=%0d: got a=%0d/%0b b=%0d/%0b en=%0b hn=%0b exp a=%0d/%0b b=%0d/%0b en=%0b hn=%0b",
                     req, m_idx, a_mag, a_neg, b_mag, b_neg, out_en, home_n,
                     ea, ean, eb, ebn, drv, eh);
        end
    endtask

    task automatic pulse(bit moves);
        step_in = 1'b1; settle(6);
        if (moves) m_idx = (m_idx + (dir_cw ? stride(res_code) : 128 - stride(res_code))) % 128;
        step_in = 1'b0; settle(4);
    endtask

    task automatic t_reset;
        settle(3); rst_n = 1'b1; settle(4);
        check("R1 reset home", 1);
        n_chk++;
        if (!chop_run) begin n_bad++; $display("FAIL R1 chop_run got 0 exp 1"); end
    endtask

    task automatic t_fine_cw;
        res_code = 3'd7; dir_cw = 1'b1; settle(3);
        for (int i = 0; i < 130; i++) begin
            pulse(1);
            if (i % 5 == 0 || i > 120) check("R4 fine cw", 1);
        end
    endtask

    task automatic t_edge_only;
        step_in = 1'b1; settle(6);
        m_idx = (m_idx + 1) % 128;
        check("R2 rise moves", 1);
        step_in = 1'b0; settle(6);
        check("R2 fall no move", 1);
    endtask

    task automatic t_ccw_wrap;
        res_code = 3'd6; dir_cw = 1'b0; settle(3);
        for (int i = 0; i < 40; i++) begin
            pulse(1);
            check("R3 ccw 1/16 wrap", 1);
        end
    endtask

    task automatic go_home;
        home_i = 1'b1; settle(3);
        m_idx = 16;
        step_in = 1'b1; settle(6); step_in = 1'b0; settle(3);
        check("R7 home held", 1);
        home_i = 1'b0; settle(3);
    endtask

    task automatic t_modes;
        logic [2:0] codes [4] = '{3'd1, 3'd2, 3'd4, 3'd3};
        for (int c = 0; c < 4; c++) begin
            res_code = codes[c]; dir_cw = 1'b1; settle(3);
            go_home();
            check("R5 mode home", 1);
            for (int i = 0; i < 6; i++) begin
                pulse(1);
                check("R5 mode step", 1);
            end
        end
    endtask

    task automatic t_torque;
        res_code = 3'd5; settle(3);
        pulse(1);
        for (int t = 0; t < 4; t++) begin
            torque = 2'(t); settle(3);
            check("R6 torque", 1);
        end
    endtask

    task automatic t_disable;
        enable_i = 1'b0; settle(3);
        check("R9 disabled", 0);
        pulse(0);
        check("R9 step ignored", 0);
        enable_i = 1'b1; settle(3);
        check("R9 restored", 1);
    endtask

    task automatic t_standby;
        logic [2:0] keep = res_code;
        res_code = 3'd0; settle(3);
        check("R10 standby", 0);
        n_chk++;
        if (chop_run) begin n_bad++; $display("FAIL R10 chop_run got 1 exp 0"); end
        pulse(0);
        res_code = keep; settle(3);
        check("R10 resumed", 1);
        n_chk++;
        if (!chop_run) begin n_bad++; $display("FAIL R10 chop_run got 0 exp 1"); end
    endtask

    task automatic t_flag;
        res_code = 3'd7; dir_cw = 1'b1; settle(2);
        go_home();
        check("R8 flag low at home", 1);
        pulse(1);
        check("R8 flag high away", 1);
    endtask

    initial begin
        t_reset();
        t_fine_cw();
        t_edge_only();
        t_ccw_wrap();
        t_modes();
        t_torque();
        t_disable();
        t_standby();
        t_flag();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule